// File: doc/BRIEF.md
# Burst Memory Wait-State Sequencer

This block sits on the memory side of a processor bus and decides when each data beat of a request is ready. A request is one four-beat burst or, with burst mode off, four accesses that each pay the full first-access cost. Two small configuration inputs set the timing profile. The lead-off count `x` sets how long the first beat takes. The burst count `y` sets how long each of the three following beats takes. Together they give profiles such as 5-2-2-2, 3-1-1-1 or 2-1-1-1. In non-burst mode every beat costs `x`.

The sequencer takes a request when `req_valid_i` is high and `busy_o` is low. It samples the timing profile, mode and direction in that cycle. It then counts cycles per beat. On each beat it raises a one-cycle ready strobe with a 2-bit beat index and gates the 64-bit read or write data for that beat. A done strobe marks the fourth beat. No DRAM commands are modelled: the block only paces the handshake.

Top module: `bws_seq`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid_i` is high and `busy_o` is low. `busy_o` is high from the next cycle up to and including the done cycle, and low in the cycle after. A request presented in that first low cycle is accepted.
- R2: With `req_burst_i`=1 and acceptance in cycle c, beat k (k=0..3) is ready in cycle c+x+k*y. The last beat therefore lands x+3y cycles after the request: 11 for 5-2-2-2 and 60 for 15-15-15-15.
- R3: With `req_burst_i`=0, beat k is ready in cycle c+(k+1)*x. A lead-off of 5 puts the last beat 20 cycles after the request.
- R4: `x` and `y` are 4-bit unsigned, and a value of 0 counts as 1. The first beat always costs `x` and never `y`, so lead-offs of 2 or 3 combined with a burst count of 1 give 2-1-1-1 and 3-1-1-1.
- R5: Timing counts, mode and direction are taken only in the acceptance cycle. Changing them during a request does not alter that request's beats.
- R6: `rdy_o` is high for exactly one cycle per beat, with `beat_o` equal to 0, 1, 2, 3 in order. `done_o` is high only together with the beat-3 ready.
- R7: Requests presented while `busy_o` is high are ignored. They produce no extra beats and do not delay the fall of `busy_o`.
- R8: On a read beat, `rdata_o` equals `mem_rdata_i`. On a write beat, `wr_en_o` is high and `wdata_o` equals `wdata_i`. In every other cycle `rdata_o`, `wr_en_o` and `wdata_o` are zero.
- R9: Driving `rst_ni` low immediately clears `busy_o`, `rdy_o` and `done_o` and abandons any request in progress. The sequencer is idle again two cycles after `rst_ni` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Request strobe |
| req_burst_i | input | 1 | 1 = burst timing, 0 = every beat pays the lead-off |
| req_write_i | input | 1 | 1 = write, 0 = read |
| lead_cyc_i | input | 4 | Lead-off cycle count x |
| burst_cyc_i | input | 4 | Later-beat cycle count y |
| wdata_i | input | 64 | Write data from requester |
| mem_rdata_i | input | 64 | Read data from storage |
| busy_o | output | 1 | Request in progress, new requests refused |
| rdy_o | output | 1 | Beat ready strobe |
| beat_o | output | 2 | Index of current beat |
| done_o | output | 1 | Final beat strobe |
| rdata_o | output | 64 | Read data, valid on read beats |
| wr_en_o | output | 1 | Write strobe on write beats |
| wdata_o | output | 64 | Write data, valid on write beats |

## Verification
The bench builds the block with its defaults: 64-bit data, 4-bit counts and four beats. The 4-bit count width lets both ends of the timing range be tested. The zero-to-one clamp, 1-1-1-1 timing, 15-15-15-15 timing and the full 60-cycle burst all fit in a short run. Four beats give 2-bit indices that cover the whole ordering, including the 5-2-2-2 total of 11 and the non-burst total of 20.

// File: rtl/bws_pkg.sv
package bws_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_e;

  typedef struct packed {
    logic burst;
    logic write;
  } req_attr_t;

endpackage

// File: rtl/bws_rst_sync.sv
module bws_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);

  logic stg_q;
  logic out_q;

  // Assertion is asynchronous; release walks through two flops.
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stg_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      stg_q <= 1'b1;
      out_q <= stg_q;
    end
  end

  assign srst_no = out_q;

endmodule

// File: rtl/bws_lat_cfg.sv
module bws_lat_cfg #(
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic             burst_mode_i,
  input  logic [LAT_W-1:0] lead_i,
  input  logic [LAT_W-1:0] burst_i,
  output logic [LAT_W-1:0] first_lat_o,
  output logic [LAT_W-1:0] next_lat_o
);

  localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

  logic [LAT_W-1:0] lead_c;
  logic [LAT_W-1:0] burst_c;
  logic [LAT_W-1:0] next_d;
  logic [LAT_W-1:0] next_q;

  // A zero count behaves as one.
  always_comb begin
    lead_c  = (lead_i  == '0) ? ONE : lead_i;
    burst_c = (burst_i == '0) ? ONE : burst_i;
    next_d  = burst_mode_i ? burst_c : lead_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= ONE;
    end else if (cap_en_i) begin
      next_q <= next_d;
    end
  end

  assign first_lat_o = lead_c;
  assign next_lat_o  = next_q;

endmodule

// File: rtl/bws_cyc_ctr.sv
module bws_cyc_ctr #(
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] val_i,
  output logic             zero_o
);

  logic [LAT_W-1:0] cnt_q;
  logic [LAT_W-1:0] cnt_d;
  logic             cnt_en;

  // val_i is never zero, so val_i-1 cannot wrap.
  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? (val_i - LAT_W'(1)) : (cnt_q - LAT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bws_beat_fsm.sv
module bws_beat_fsm
  import bws_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             expire_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             rdy_o,
  output logic             last_o,
  output logic [IDX_W-1:0] beat_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] beat_q, beat_d;
  logic             beat_en;

  always_comb begin
    accept_o = (st_q == ST_IDLE) && req_i;
    rdy_o    = (st_q == ST_RUN) && expire_i;
    last_o   = rdy_o && (beat_q == LAST_IDX);
    st_d     = st_q;
    beat_d   = beat_q;
    beat_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept_o) begin
          st_d    = ST_RUN;
          beat_d  = '0;
          beat_en = 1'b1;
        end
      end
      ST_RUN: begin
        if (last_o) begin
          st_d = ST_IDLE;
        end else if (rdy_o) begin
          beat_d  = beat_q + IDX_W'(1);
          beat_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  assign busy_o = (st_q == ST_RUN);
  assign beat_o = beat_q;

endmodule

// File: rtl/bws_seq.sv
module bws_seq
  import bws_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LAT_W  = 4,
  parameter int BEATS  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic                       req_burst_i,
  input  logic                       req_write_i,
  input  logic [LAT_W-1:0]           lead_cyc_i,
  input  logic [LAT_W-1:0]           burst_cyc_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [DATA_W-1:0]          mem_rdata_i,
  output logic                       busy_o,
  output logic                       rdy_o,
  output logic [$clog2(BEATS)-1:0]   beat_o,
  output logic                       done_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       wr_en_o,
  output logic [DATA_W-1:0]          wdata_o
);

  localparam int IDX_W = $clog2(BEATS);

  logic             rst_sync_n;
  logic             accept;
  logic             last;
  logic             expire;
  logic             ctr_load;
  logic [LAT_W-1:0] first_lat;
  logic [LAT_W-1:0] next_lat;
  logic [LAT_W-1:0] load_val;
  logic [IDX_W-1:0] beat_idx;
  req_attr_t        attr_q;
  req_attr_t        attr_d;

  bws_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (rst_sync_n)
  );

  bws_lat_cfg #(.LAT_W(LAT_W)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .cap_en_i     (accept),
    .burst_mode_i (req_burst_i),
    .lead_i       (lead_cyc_i),
    .burst_i      (burst_cyc_i),
    .first_lat_o  (first_lat),
    .next_lat_o   (next_lat)
  );

  bws_cyc_ctr #(.LAT_W(LAT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .load_i (ctr_load),
    .val_i  (load_val),
    .zero_o (expire)
  );

  bws_beat_fsm #(.BEATS(BEATS)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .req_i    (req_valid_i),
    .expire_i (expire),
    .accept_o (accept),
    .busy_o   (busy_o),
    .rdy_o    (rdy_o),
    .last_o   (last),
    .beat_o   (beat_idx)
  );

  // Counter restarts on acceptance (lead-off) and after each non-final beat.
  always_comb begin
    ctr_load     = accept || (rdy_o && !last);
    load_val     = accept ? first_lat : next_lat;
    attr_d.burst = req_burst_i;
    attr_d.write = req_write_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      attr_q <= '0;
    end else if (accept) begin
      attr_q <= attr_d;
    end
  end

  always_comb begin
    wr_en_o = rdy_o && attr_q.write;
    rdata_o = (rdy_o && !attr_q.write) ? mem_rdata_i : '0;
    wdata_o = wr_en_o ? wdata_i : '0;
  end

  assign beat_o = beat_idx;
  assign done_o = last;

endmodule

// File: rtl/bws_seq_chk.sv
module bws_seq_chk #(
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_s_i,
  input logic             req_valid_i,
  input logic             busy_o,
  input logic             rdy_o,
  input logic             done_o,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] beat_o
);

  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && rst_s_i) |=> busy_o); // R1

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R1

  AST_BUSY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R7

  AST_RDY_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> busy_o); // R6

  AST_DONE_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rdy_o && beat_o == IDX_W'(BEATS - 1))); // R6

  AST_BEAT_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !done_o) |=> (beat_o == IDX_W'($past(beat_o) + IDX_W'(1)))); // R6

  AST_FIRST_BEAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (beat_o == '0)); // R6

  AST_WRITE_ON_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> rdy_o); // R8

endmodule

bind bws_seq bws_seq_chk #(.BEATS(BEATS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_s_i     (rst_sync_n),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .rdy_o       (rdy_o),
  .done_o      (done_o),
  .wr_en_o     (wr_en_o),
  .beat_o      (beat_o)
);

// File: tb/tb_bws_seq.sv
module tb_bws_seq;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_burst_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [3:0]  lead_cyc_i = 4'd0;
  logic [3:0]  burst_cyc_i = 4'd0;
  logic [63:0] wdata_i = '0;
  logic [63:0] mem_rdata_i = '0;
  logic        busy_o, rdy_o, done_o, wr_en_o;
  logic [1:0]  beat_o;
  logic [63:0] rdata_o, wdata_o;

  bws_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_burst_i(req_burst_i), .req_write_i(req_write_i),
    .lead_cyc_i(lead_cyc_i), .burst_cyc_i(burst_cyc_i),
    .wdata_i(wdata_i), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .rdy_o(rdy_o), .beat_o(beat_o), .done_o(done_o),
    .rdata_o(rdata_o), .wr_en_o(wr_en_o), .wdata_o(wdata_o)
  );

  always #4 clk_i = ~clk_i;

  typedef struct {
    int          cyc;
    int          beat;
    bit          last;
    bit          wr;
    logic [63:0] data;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  int   wd = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Driver: presents one request and queues the beats the requirements predict.
  task automatic send(input int x, input int y, input bit burst, input bit wr,
                      input logic [63:0] pat, input string tag);
    int xe, ye, c;
    while (busy_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_burst_i = burst; req_write_i = wr;
    lead_cyc_i = 4'(x); burst_cyc_i = 4'(y);
    wdata_i = pat; mem_rdata_i = pat;
    c  = cyc;
    xe = (x == 0) ? 1 : x;
    ye = (y == 0) ? 1 : y;
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      e.cyc  = burst ? (c + xe + k * ye) : (c + (k + 1) * xe);
      e.beat = k; e.last = (k == 3); e.wr = wr; e.data = pat; e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(busy_o == 1'b1, "R1", "busy after accept", 64'(busy_o), 1);
  endtask

  // Returns in the first cycle after done; busy must already be low there.
  task automatic wait_idle();
    while (sb.size() != 0) @(posedge clk_i);
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R1", "busy after done", 64'(busy_o), 0);
  endtask

  // Monitor: pops and compares as beats appear.
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (sb.size() > 0 && sb[0].cyc < cyc) begin
        chk(1'b0, sb[0].tag, "missed beat timing", 64'(cyc), 64'(sb[0].cyc));
        void'(sb.pop_front());
      end
      if (rdy_o) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7", "unexpected ready", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.cyc, e.tag, "beat cycle", 64'(cyc), 64'(e.cyc));
          chk(int'(beat_o) == e.beat, "R6", "beat index", 64'(beat_o), 64'(e.beat));
          chk(done_o == e.last, "R6", "done with beat", 64'(done_o), 64'(e.last));
          chk(wr_en_o == e.wr, "R8", "write strobe", 64'(wr_en_o), 64'(e.wr));
          chk(rdata_o == (e.wr ? 64'd0 : e.data), "R8", "read data", rdata_o,
              e.wr ? 64'd0 : e.data);
          chk(wdata_o == (e.wr ? e.data : 64'd0), "R8", "write data", wdata_o,
              e.wr ? e.data : 64'd0);
        end
      end else begin
        chk(done_o == 1'b0, "R6", "done without ready", 64'(done_o), 0);
        chk(wr_en_o == 1'b0 && rdata_o == '0 && wdata_o == '0, "R8",
            "data idle", rdata_o | wdata_o | 64'(wr_en_o), 0);
      end
    end
  end

  always @(posedge clk_i) begin
    wd <= wd + 1;
    if (wd > 50000) begin
      chk(1'b0, "WD", "watchdog expired", 64'(wd), 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && rdy_o == 0 && done_o == 0, "R9", "state in reset",
        64'({busy_o, rdy_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && rdy_o == 0, "R9", "idle after release", 64'({busy_o, rdy_o}), 0);

    send(5, 2, 1'b1, 1'b0, 64'hA5A5_0000_1111_2222, "R2"); wait_idle();  // last at +11
    send(5, 9, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, "R3"); wait_idle();  // last at +20
    send(2, 1, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_0002, "R4"); wait_idle();
    send(3, 1, 1'b1, 1'b0, 64'h3333_1111_3333_1111, "R4"); wait_idle();
    send(0, 0, 1'b1, 1'b1, 64'h0000_0000_0000_00FF, "R4"); wait_idle();
    send(0, 7, 1'b0, 1'b0, 64'h7070_7070_7070_7070, "R4"); wait_idle();
    send(3, 3, 1'b1, 1'b1, 64'hFEDC_BA98_7654_3210, "R2"); wait_idle();
    send(15, 15, 1'b1, 1'b0, 64'hFFFF_0000_FFFF_0000, "R2"); wait_idle(); // last at +60

    // Back-to-back: each request enters in the first idle cycle (R1).
    send(1, 1, 1'b1, 1'b0, 64'h1111_1111_1111_1111, "R1"); wait_idle();
    send(2, 2, 1'b0, 1'b1, 64'h2222_2222_2222_2222, "R1"); wait_idle();

    // Config and requests change during a burst: ignored (R5, R7).
    send(5, 2, 1'b1, 1'b0, 64'h5555_AAAA_5555_AAAA, "R5");
    req_valid_i = 1'b1; lead_cyc_i = 4'd1; burst_cyc_i = 4'd1;
    req_burst_i = 1'b0; req_write_i = 1'b1;
    repeat (6) @(negedge clk_i);
    req_valid_i = 1'b0;
    wait_idle();

    // Reset in the middle of a burst (R9).
    send(6, 3, 1'b1, 1'b1, 64'h9999_0000_9999_0000, "R9");
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(busy_o == 0 && rdy_o == 0 && done_o == 0, "R9", "async clear",
        64'({busy_o, rdy_o, done_o}), 0);
    sb.delete();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0, "R9", "idle after mid-burst reset", 64'(busy_o), 0);
    send(4, 2, 1'b1, 1'b0, 64'hCAFE_F00D_CAFE_F00D, "R9"); wait_idle();

    repeat (5) @(negedge clk_i);
    chk(sb.size() == 0, "R6", "beats left over", 64'(sb.size()), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule